// File: doc/BRIEF.md
# Status Packet Transmitter with Clock-Correction Gating

This block builds the response frames that a shared-memory adapter returns to the host adapters on a serial backplane, and streams them as 16-bit halfwords over a source/destination-ready framed interface with start- and end-of-frame marks. Each request that reaches it, whether lock, unlock, shared-memory read, shared-memory write, or one whose receive check failed, is turned into one frame of 32-bit words. The frame holds an address word, a status word, one or more data or padding words, and a zero word kept as the slot for the transceiver's CRC. Each word goes out upper half first.

A free-running interval counter requests a clock-correction sequence once per period. It also drives two early warnings, one sized for short frames and one for long frames. A frame is launched only while the warning for its size is clear, so every frame ends before correction begins. A frame that is already under way always finishes. Read data is pulled from an external source one halfword at a time. A one-cycle done pulse marks the accepted end of each frame.

Top module: `rsp_status_tx`

## Requirements
- R1: A frame is sent as halfwords in the order address word, status word, data/padding words, then one all-zero CRC slot word. The upper 16 bits of each word are sent before the lower 16 bits, and the address word repeats the request address.
- R2: For a request without error, the status word carries the request transfer count in bits 16:8, copies request control bits 3:0 (3 = bus request, 2 = read, 1 = unlock, 0 = lock) into bits 3:0, sets bit 4 (complete), and has every other bit zero. A lock request of 0x000000A1 therefore gives status 0x00000011.
- R3: Lock, unlock and write responses always have exactly 3 data/padding words, giving 12 halfwords. For a lock or unlock, the first data word is the semaphore byte zero-extended into bits 7:0. All other padding words are zero.
- R4: A read response (control bits 3 and 2 both set) sends the N requested halfwords in source order, each popped with a one-cycle pop strobe. An odd N leaves a zero lower half. The data area is max(3, ceil(N/2)) words, so the frame is 2*max(3,ceil(N/2))+6 halfwords long.
- R5: A request marked with a receive error waits until the receive-FIFO-empty input is high. It then sends address 0xBAADAAAA, status 0x00000030 and three data words of 0xBAADBAAD, whatever the request's type and count.
- R6: The clock-correction request is high for exactly one cycle in every CC_PERIOD cycles, on counter phase CC_PERIOD-1. The phase is 0 during reset and advances by one per cycle after reset.
- R7: The small-frame warning is high at phases at or above CC_PERIOD-SMALL_GUARD and at phases below CC_LEN. The large-frame warning is high at phases at or above CC_PERIOD-BIG_GUARD and at phases below CC_LEN.
- R8: A frame starts one cycle after the first cycle of its wait in which its class warning is clear. Read responses use the large-frame warning and all other responses use the small-frame warning. A held frame therefore starts at phase CC_LEN+1.
- R9: Once the first halfword has been presented, the frame continues to its end even when a warning rises during the frame.
- R10: The first halfword is marked start-of-frame and the last is marked end-of-frame. While the destination is not ready, the data and marks stay unchanged.
- R11: The done output pulses for one cycle, in the same cycle that the end-of-frame halfword is accepted.
- R12: A request strobe that arrives while a frame is waiting or being sent is ignored. It neither alters that frame nor causes a later one.
- R13: Under reset, source-ready, done and pop are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_addr | input | 32 | Address of the request |
| req_ctrl | input | 32 | Control word of the request |
| req_sem | input | 8 | Semaphore byte result for lock/unlock |
| req_crc_err | input | 1 | Request failed its receive check |
| rx_fifo_empty | input | 1 | Receive FIFO has drained |
| rd_hw | input | 16 | Head halfword of the read data source |
| rd_pop | output | 1 | Head halfword consumed this cycle |
| tx_data | output | 16 | Outgoing halfword |
| tx_sof | output | 1 | Start of frame |
| tx_eof | output | 1 | End of frame |
| tx_src_rdy | output | 1 | Halfword valid |
| tx_dst_rdy | input | 1 | Sink accepts halfword |
| tx_done | output | 1 | Frame finished pulse |
| cc_req | output | 1 | Clock-correction request |
| warn_small | output | 1 | Guard warning for short frames |
| warn_big | output | 1 | Guard warning for long frames |

## Verification
The bench builds the block with a 200-cycle correction period, a 6-cycle correction window, a 12-cycle small guard and a 24-cycle large guard. At that size the counter wraps every few frames, so the bench can sweep read counts 0 to 16 and hit the exact last legal start phase and the first held phase of each frame class. It also covers a short frame launched inside the large-only window and a short frame whose warning rises mid-frame. With these guards the longest bench read (22 halfwords) ends two cycles before correction.

// File: rtl/rsp_tx_pkg.sv
// Shared types and constants for the status packet transmitter.
// Assumes the fixed 32-bit word layout of the response frame.
package rsp_tx_pkg;

    localparam logic [31:0] ERR_ADDR   = 32'hBAAD_AAAA;
    localparam logic [31:0] ERR_STATUS = 32'h0000_0030;
    localparam logic [31:0] ERR_DATA   = 32'hBAAD_BAAD;
    localparam int          MIN_DWORDS = 3;

    // Captured request, reduced to the fields that shape the frame.
    typedef struct packed {
        logic [31:0] addr;
        logic [8:0]  xfr;
        logic [3:0]  kind;
        logic [7:0]  sem;
        logic        err;
        logic        rd;
    } rsp_req_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_HOLD = 2'd1,
        SQ_SEND = 2'd2
    } seq_state_t;

    // Status word of a response.
    function automatic logic [31:0] status_word(input rsp_req_t r);
        if (r.err) return ERR_STATUS;
        return {15'd0, r.xfr, 2'b00, 1'b0, 1'b1, r.kind};
    endfunction

endpackage

// File: rtl/rsp_cc_timer.sv
// Free-running clock-correction interval counter.
// Raises a one-cycle correction request at the end of each period and two
// guard warnings that cover the tail of the period and the correction window.
// Assumes CC_LEN >= 1 and both guards below CC_PERIOD - CC_LEN.
module rsp_cc_timer #(
    parameter int CC_PERIOD   = 5000,
    parameter int CC_LEN      = 8,
    parameter int SMALL_GUARD = 16,
    parameter int BIG_GUARD   = 520
) (
    input  logic clk,
    input  logic rst_n,
    output logic cc_req,
    output logic warn_small,
    output logic warn_big
);
    localparam int CW = $clog2(CC_PERIOD);
    localparam logic [CW-1:0] PH_LAST  = CW'(CC_PERIOD - 1);
    localparam logic [CW-1:0] PH_SMALL = CW'(CC_PERIOD - SMALL_GUARD);
    localparam logic [CW-1:0] PH_BIG   = CW'(CC_PERIOD - BIG_GUARD);
    localparam logic [CW-1:0] PH_CCEND = CW'(CC_LEN);

    logic [CW-1:0] phase_q;
    logic          in_cc;

    // Advance the phase, wrapping after the last phase of the period.
    always_ff @(posedge clk) begin
        if (!rst_n)                phase_q <= '0;
        else if (phase_q == PH_LAST) phase_q <= '0;
        else                       phase_q <= phase_q + 1'b1;
    end

    // Decode request and warnings from the phase.
    always_comb begin
        in_cc      = phase_q < PH_CCEND;
        cc_req     = phase_q == PH_LAST;
        warn_small = in_cc || (phase_q >= PH_SMALL);
        warn_big   = in_cc || (phase_q >= PH_BIG);
    end

endmodule

// File: rtl/rsp_frame_seq.sv
// Frame sequencer: captures a request while idle, holds it until the warning
// for its frame class is clear (and, after a receive error, until the receive
// FIFO is empty), then walks the halfword index to the frame's last index.
// Assumes the sink follows source/destination-ready acceptance.
module rsp_frame_seq
    import rsp_tx_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  rsp_req_t         req_in,
    input  logic             warn_small,
    input  logic             warn_big,
    input  logic             rx_empty,
    input  logic             dst_rdy,
    output rsp_req_t         cur,
    output logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] last,
    output logic             src_rdy,
    output logic             sof,
    output logic             eof,
    output logic             done
);
    seq_state_t state_q;
    logic       go;
    logic       acc;

    // Last halfword index of the frame this request produces.
    function automatic logic [IDX_W-1:0] last_of(input rsp_req_t r);
        logic [9:0] dw;
        dw = ({1'b0, r.xfr} + 10'd1) >> 1;
        if (r.rd && dw > 10'(MIN_DWORDS)) return IDX_W'({dw, 1'b0} + 11'd5);
        return IDX_W'(2 * MIN_DWORDS + 5);
    endfunction

    // Launch and acceptance conditions.
    always_comb begin
        go      = (cur.rd ? !warn_big : !warn_small) && (!cur.err || rx_empty);
        src_rdy = state_q == SQ_SEND;
        acc     = src_rdy && dst_rdy;
        sof     = src_rdy && (idx == '0);
        eof     = src_rdy && (idx == last);
        done    = acc && (idx == last);
    end

    // Request capture, hold and halfword walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cur     <= '0;
            idx     <= '0;
            last    <= '0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    idx <= '0;
                    if (req_valid) begin
                        cur     <= req_in;
                        last    <= last_of(req_in);
                        state_q <= SQ_HOLD;
                    end
                end
                SQ_HOLD: begin
                    if (go) state_q <= SQ_SEND;
                end
                SQ_SEND: begin
                    if (acc) begin
                        if (idx == last) state_q <= SQ_IDLE;
                        else             idx     <= idx + 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rsp_word_fmt.sv
// Halfword formatter: picks the outgoing halfword from the frame index and the
// captured request, and pops the read source for each read data halfword.
// Assumes the read source shows its head halfword whenever it is needed.
module rsp_word_fmt
    import rsp_tx_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  rsp_req_t         cur,
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] last,
    input  logic             active,
    input  logic             dst_rdy,
    input  logic [15:0]      rd_hw,
    output logic [15:0]      hw_out,
    output logic             pop
);
    localparam logic [IDX_W-1:0] IX_STAT = IDX_W'(2);
    localparam logic [IDX_W-1:0] IX_DATA = IDX_W'(4);
    localparam logic [IDX_W-1:0] IX_ONE  = IDX_W'(1);

    logic [31:0]      addr_w;
    logic [31:0]      stat_w;
    logic [IDX_W-1:0] k;
    logic             upper;
    logic             need;

    // Select the halfword for the current index.
    always_comb begin
        addr_w = cur.err ? ERR_ADDR : cur.addr;
        stat_w = status_word(cur);
        k      = idx - IX_DATA;
        upper  = !idx[0];
        need   = 1'b0;
        hw_out = '0;
        if (idx < IX_STAT) begin
            hw_out = upper ? addr_w[31:16] : addr_w[15:0];
        end else if (idx < IX_DATA) begin
            hw_out = upper ? stat_w[31:16] : stat_w[15:0];
        end else if (idx >= last - IX_ONE) begin
            hw_out = '0;
        end else if (cur.err) begin
            hw_out = upper ? ERR_DATA[31:16] : ERR_DATA[15:0];
        end else if (cur.rd) begin
            if (k < IDX_W'(cur.xfr)) begin
                need   = 1'b1;
                hw_out = rd_hw;
            end
        end else if (cur.kind[1:0] != 2'b00 && k == IX_ONE) begin
            hw_out = {8'h00, cur.sem};
        end
        pop = active && dst_rdy && need;
    end

endmodule

// File: rtl/rsp_status_tx.sv
// Status packet transmitter top: ties the correction timer, the frame
// sequencer and the halfword formatter together.
// Assumes SMALL_GUARD >= 12 and BIG_GUARD >= the longest read frame issued,
// and that the sink stays ready during the guard window.
module rsp_status_tx
    import rsp_tx_pkg::*;
#(
    parameter int CC_PERIOD   = 5000,
    parameter int CC_LEN      = 8,
    parameter int SMALL_GUARD = 16,
    parameter int BIG_GUARD   = 520
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_ctrl,
    input  logic [7:0]  req_sem,
    input  logic        req_crc_err,
    input  logic        rx_fifo_empty,
    input  logic [15:0] rd_hw,
    output logic        rd_pop,
    output logic [15:0] tx_data,
    output logic        tx_sof,
    output logic        tx_eof,
    output logic        tx_src_rdy,
    input  logic        tx_dst_rdy,
    output logic        tx_done,
    output logic        cc_req,
    output logic        warn_small,
    output logic        warn_big
);
    localparam int MAX_HW = 2 * ((1 << 9) / 2) + 6;
    localparam int IDX_W  = $clog2(MAX_HW);

    rsp_req_t         req_in;
    rsp_req_t         cur;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last;
    logic             unused_ctrl;

    // Reduce the request ports to the captured request.
    always_comb begin
        req_in.addr = req_addr;
        req_in.xfr  = req_ctrl[16:8];
        req_in.kind = req_ctrl[3:0];
        req_in.sem  = req_sem;
        req_in.err  = req_crc_err;
        req_in.rd   = req_ctrl[3] && req_ctrl[2] && !req_crc_err;
        unused_ctrl = ^{req_ctrl[31:17], req_ctrl[7:4]};
    end

    rsp_cc_timer #(
        .CC_PERIOD  (CC_PERIOD),
        .CC_LEN     (CC_LEN),
        .SMALL_GUARD(SMALL_GUARD),
        .BIG_GUARD  (BIG_GUARD)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .cc_req    (cc_req),
        .warn_small(warn_small),
        .warn_big  (warn_big)
    );

    rsp_frame_seq #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_in    (req_in),
        .warn_small(warn_small),
        .warn_big  (warn_big),
        .rx_empty  (rx_fifo_empty),
        .dst_rdy   (tx_dst_rdy),
        .cur       (cur),
        .idx       (idx),
        .last      (last),
        .src_rdy   (tx_src_rdy),
        .sof       (tx_sof),
        .eof       (tx_eof),
        .done      (tx_done)
    );

    rsp_word_fmt #(.IDX_W(IDX_W)) u_fmt (
        .cur    (cur),
        .idx    (idx),
        .last   (last),
        .active (tx_src_rdy),
        .dst_rdy(tx_dst_rdy),
        .rd_hw  (rd_hw),
        .hw_out (tx_data),
        .pop    (rd_pop)
    );

endmodule

// File: rtl/rsp_tx_chk.sv
// Protocol checker for the status packet transmitter, bound to the top.
module rsp_tx_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tx_src_rdy,
    input logic        tx_dst_rdy,
    input logic        tx_sof,
    input logic        tx_eof,
    input logic        tx_done,
    input logic        cc_req,
    input logic        warn_small,
    input logic        warn_big,
    input logic [15:0] tx_data
);
    // R8: a frame only begins after a cycle with the small warning clear
    assert_start_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_src_rdy) |-> !$past(warn_small));

    // R10: the first presented halfword carries start-of-frame
    assert_first_sof_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_src_rdy) |-> tx_sof);

    // R10: a stalled halfword is held unchanged
    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_src_rdy && !tx_dst_rdy) |=> (tx_src_rdy && $stable(tx_data)
                                         && $stable(tx_sof) && $stable(tx_eof)));

    // R11: done is a single pulse and ends the frame
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> (!tx_done && !tx_src_rdy));

    // R6: the correction request lasts one cycle
    assert_ccreq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cc_req |=> !cc_req);

    // R7: both warnings cover the correction window that follows a request
    assert_warn_in_cc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cc_req |=> (warn_small && warn_big));
endmodule

bind rsp_status_tx rsp_tx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_src_rdy(tx_src_rdy),
    .tx_dst_rdy(tx_dst_rdy),
    .tx_sof    (tx_sof),
    .tx_eof    (tx_eof),
    .tx_done   (tx_done),
    .cc_req    (cc_req),
    .warn_small(warn_small),
    .warn_big  (warn_big),
    .tx_data   (tx_data)
);

// File: tb/tb_rsp_status_tx.sv
`timescale 1ns/100ps
module tb_rsp_status_tx;
    localparam int P   = 200;
    localparam int CCL = 6;
    localparam int SG  = 12;
    localparam int BG  = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_ctrl = '0;
    logic [7:0]  req_sem = '0;
    logic        req_crc_err = 1'b0;
    logic        rx_fifo_empty = 1'b1;
    logic [15:0] rd_hw;
    logic        rd_pop;
    logic [15:0] tx_data;
    logic        tx_sof, tx_eof, tx_src_rdy, tx_done;
    logic        tx_dst_rdy = 1'b1;
    logic        cc_req, warn_small, warn_big;

    int  checks = 0;
    int  errors = 0;
    int  k = 0;
    int  phase;
    int  pops = 0;
    int  pop_base = 0;
    bit  stall_en = 1'b0;
    bit  finished = 1'b0;

    logic [15:0] cap [0:63];
    int  ncap = 0;
    bit  frame_done = 1'b0;
    int  sof_phase = 0, eof_phase = 0;
    int  proto_bad = 0, done_cnt = 0, idle_src = 0;
    logic [15:0] prev_data = '0;
    bit  prev_stall = 1'b0;

    logic [31:0] e_addr, e_ctrl;
    logic [7:0]  e_sem;
    logic        e_err;

    always #2.5 clk = ~clk;

    assign phase = k % P;
    assign rd_hw = 16'(32'hA000 + pops - pop_base);

    rsp_status_tx #(.CC_PERIOD(P), .CC_LEN(CCL), .SMALL_GUARD(SG), .BIG_GUARD(BG)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ctrl(req_ctrl), .req_sem(req_sem), .req_crc_err(req_crc_err),
        .rx_fifo_empty(rx_fifo_empty), .rd_hw(rd_hw), .rd_pop(rd_pop),
        .tx_data(tx_data), .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_src_rdy(tx_src_rdy),
        .tx_dst_rdy(tx_dst_rdy), .tx_done(tx_done), .cc_req(cc_req),
        .warn_small(warn_small), .warn_big(warn_big));

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Model time base and read source.
    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
        if (rd_pop) pops <= pops + 1;
    end

    // Sink readiness.
    always @(posedge clk) begin
        #1;
        tx_dst_rdy = stall_en ? ((k % 3) != 0) : 1'b1;
    end

    // Monitor: timer model and frame capture.
    always @(negedge clk) begin
        if (rst_n) begin
            chk((cc_req == (phase == P - 1)) &&
                (warn_small == ((phase >= P - SG) || (phase < CCL))) &&
                (warn_big == ((phase >= P - BG) || (phase < CCL))),
                "R6 R7 timer outputs", {cc_req, warn_small, warn_big}, phase);
            if (tx_src_rdy) idle_src++;
            if (prev_stall && tx_data != prev_data) proto_bad++;
            if (tx_done != (tx_src_rdy && tx_dst_rdy && tx_eof)) proto_bad++;
            if (tx_done) done_cnt++;
            if (tx_src_rdy && tx_dst_rdy) begin
                if (ncap < 64) cap[ncap] = tx_data;
                if (tx_sof != (ncap == 0)) proto_bad++;
                if (ncap == 0) sof_phase = phase;
                if (tx_eof) begin
                    frame_done = 1'b1;
                    eof_phase  = phase;
                end
                ncap++;
            end
            prev_stall = tx_src_rdy && !tx_dst_rdy;
            prev_data  = tx_data;
        end
    end

    function automatic int exp_len(input logic [31:0] c, input logic e);
        int n, dw;
        n  = (c[3] && c[2] && !e) ? int'(c[16:8]) : 0;
        dw = (n + 1) / 2;
        if (dw < 3) dw = 3;
        return 2 * dw + 6;
    endfunction

    function automatic logic [15:0] exp_hw(input logic [31:0] a, input logic [31:0] c,
                                           input logic [7:0] s, input logic e, input int idx);
        logic rd;
        int n, kk;
        logic [31:0] ad, st;
        rd = c[3] && c[2] && !e;
        n  = rd ? int'(c[16:8]) : 0;
        ad = e ? 32'hBAAD_AAAA : a;
        st = e ? 32'h0000_0030 : ((c & 32'h0001_FF0F) | 32'h10);
        if (idx < 2) return (idx == 0) ? ad[31:16] : ad[15:0];
        if (idx < 4) return (idx == 2) ? st[31:16] : st[15:0];
        if (idx >= exp_len(c, e) - 2) return 16'h0000;
        kk = idx - 4;
        if (e) return 16'hBAAD;
        if (rd) return (kk < n) ? 16'(32'hA000 + kk) : 16'h0000;
        if (c[1:0] != 2'b00 && kk == 1) return {8'h00, s};
        return 16'h0000;
    endfunction

    task automatic send_req(input logic [31:0] a, input logic [31:0] c,
                            input logic [7:0] s, input logic e);
        req_addr = a; req_ctrl = c; req_sem = s; req_crc_err = e;
        req_valid = 1'b1;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic start_frame(input logic [31:0] a, input logic [31:0] c,
                               input logic [7:0] s, input logic e);
        e_addr = a; e_ctrl = c; e_sem = s; e_err = e;
        ncap = 0; frame_done = 1'b0; proto_bad = 0; done_cnt = 0;
        pop_base = pops;
        send_req(a, c, s, e);
    endtask

    task automatic finish_frame(input int exp_sof, input string tag, input bit win);
        int t, bad, first_i, L;
        t = 0;
        while (!frame_done && t < 3 * P) begin
            @(posedge clk); #1;
            t++;
        end
        L = exp_len(e_ctrl, e_err);
        chk(frame_done, {tag, " frame completes"}, int'(frame_done), 1);
        chk(ncap == L, {tag, " frame length"}, ncap, L);
        bad = 0; first_i = 0;
        for (int i = 0; i < L && i < ncap; i++) begin
            if (cap[i] != exp_hw(e_addr, e_ctrl, e_sem, e_err, i)) begin
                if (bad == 0) first_i = i;
                bad++;
            end
        end
        chk(bad == 0, {tag, " halfword content"}, int'(cap[first_i]),
            int'(exp_hw(e_addr, e_ctrl, e_sem, e_err, first_i)));
        chk(proto_bad == 0 && done_cnt == 1, {tag, " R10 R11 marks and done pulse"},
            proto_bad * 16 + done_cnt, 1);
        if (exp_sof >= 0)
            chk(sof_phase == exp_sof, {tag, " start phase"}, sof_phase, exp_sof);
        if (win)
            chk(sof_phase >= CCL && eof_phase >= sof_phase, {tag, " R8 frame clear of correction"},
                eof_phase, sof_phase);
        @(posedge clk); #1;
    endtask

    task automatic wait_phase(input int p);
        do begin
            @(posedge clk); #1;
        end while (phase != p);
    endtask

    initial begin
        int p;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R13: idle outputs after reset
        chk(!tx_src_rdy && !tx_done && !rd_pop, "R13 reset outputs",
            {tx_src_rdy, tx_done, rd_pop}, 0);
        @(posedge clk); #1;

        // R1 R2 R3: lock, unlock, write responses
        start_frame(32'h0001_2340, 32'h0000_00A1, 8'hA1, 1'b0);
        finish_frame(-1, "R1 R2 R3 lock", 1'b1);
        start_frame(32'h0000_3FFF, 32'h0000_0032, 8'h00, 1'b0);
        finish_frame(-1, "R2 R3 unlock", 1'b1);
        start_frame(32'h0007_FFF0, 32'h0000_0408, 8'h5A, 1'b0);
        finish_frame(-1, "R2 R3 write", 1'b1);

        // R4: read sweep over transfer counts
        for (int n = 0; n <= 16; n++) begin
            start_frame(32'h0004_0000 + 32'(n * 64), 32'(n << 8) | 32'h0C, 8'h00, 1'b0);
            finish_frame(-1, "R4 read", 1'b1);
        end

        // R5: error frame waits for the receive FIFO to drain
        wait_phase(20);
        rx_fifo_empty = 1'b0;
        start_frame(32'h1234_5678, 32'h0000_050C, 8'h77, 1'b1);
        repeat (30) @(posedge clk);
        #1;
        chk(ncap == 0, "R5 no frame while receive FIFO not empty", ncap, 0);
        p = phase;
        rx_fifo_empty = 1'b1;
        finish_frame(p + 1, "R5 error frame", 1'b1);

        // R8 R9: small class boundaries
        wait_phase(P - 14);
        start_frame(32'h0000_0010, 32'h0000_0001, 8'h01, 1'b0);
        finish_frame(P - 12, "R9 small last legal start", 1'b1);
        chk(eof_phase == P - 1, "R9 small frame ends at period end", eof_phase, P - 1);
        wait_phase(P - 13);
        start_frame(32'h0000_0020, 32'h0000_0001, 8'h02, 1'b0);
        finish_frame(CCL + 1, "R8 small held", 1'b1);

        // R8 R9: large class boundaries
        wait_phase(P - 26);
        start_frame(32'h0000_0100, 32'h0000_100C, 8'h00, 1'b0);
        finish_frame(P - 24, "R9 large last legal start", 1'b1);
        wait_phase(P - 25);
        start_frame(32'h0000_0200, 32'h0000_100C, 8'h00, 1'b0);
        finish_frame(CCL + 1, "R8 large held", 1'b1);
        wait_phase(P - 25);
        start_frame(32'h0000_0300, 32'h0000_0008, 8'h00, 1'b0);
        finish_frame(P - 23, "R8 small frame ignores large warning", 1'b1);

        // R10: stalled sink
        wait_phase(30);
        stall_en = 1'b1;
        start_frame(32'h0000_0400, 32'h0000_070C, 8'h00, 1'b0);
        finish_frame(-1, "R10 stalled read", 1'b0);
        stall_en = 1'b0;

        // R12: strobe during a frame is ignored
        wait_phase(30);
        start_frame(32'h0000_0500, 32'h0000_100C, 8'h00, 1'b0);
        while (ncap < 3) begin
            @(posedge clk); #1;
        end
        send_req(32'hFFFF_0000, 32'h0000_0001, 8'hEE, 1'b0);
        finish_frame(-1, "R12 frame intact", 1'b1);
        idle_src = 0;
        repeat (20) @(posedge clk);
        #1;
        chk(idle_src == 0, "R12 stray strobe ignored", idle_src, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule